// File: doc/BRIEF.md
# Dual-Base Delta Cache Line Codec

This block packs a 32-byte cache line, handled as eight 32-bit words, into a shorter form and unpacks it again. The encoder looks at a whole line in one cycle. It then reports a format code, a payload and the number of bytes that the payload occupies. Each word can be stored as a signed one-byte offset. The offset is taken either from the line's first word or from zero, and a per-word selector bit records which of the two was used. With that choice, a line that mixes pointer-like values with small integers still compresses. Two shorter formats cover lines that are entirely zero and lines that hold one value eight times.

The decoder takes a format code and a payload and rebuilds the original line. For each word it adds the sign-extended offset to the base that the selector names. Each direction has its own strobe and its own result register, so encoding and decoding can run in the same cycle. A cache fill or eviction path uses the encoder on the way into compressed storage and the decoder on the way out.

Top module: `bdi_line_codec`

## Requirements
- R1: `enc_done` is high in exactly the cycle after a cycle with `enc_valid` high, and low otherwise. The encode outputs keep their values until the next encode.
- R2: A line whose eight words are all zero gives format code 0, size 1 and an all-zero payload.
- R3: A line that is not all zero, but whose eight words are all equal, gives format code 1 and size 4. The payload carries that word in bits [31:0] and zero in every other bit.
- R4: Any other line in which every word fits one of the two bases gives format code 2 and size 13. A word fits a base when its 32-bit difference from that base equals the sign extension of the difference's low 8 bits. The payload layout is:
  - bits [31:0] hold word 0, which is the explicit base;
  - bit 32+i is 1 when word i was coded against zero and 0 when it was coded against the explicit base;
  - bits [40+8i +: 8] hold the offset of word i;
  - all bits above 103 are zero.
- R5: The zero base is tried first. A word that fits both bases has its selector bit set to 1, and its offset is the word's own low byte.
- R6: A line in which some word fits neither base gives format code 3 and size 32, and the payload equals the input line.
- R7: `dec_done` is high in exactly the cycle after a cycle with `dec_valid` high, and low otherwise.
- R8: Decoding the format code and payload produced by the encoder returns the original line, for every format.
- R9: After reset, both done outputs are low, and the format, size, payload and line outputs are zero.
- R10: Offsets of +127 and -128 from a base fit that base. Offsets of +128 and -129 do not fit it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid | input | 1 | Strobe: encode `enc_line` |
| enc_line | input | 256 | Line to encode; word i is in bits [32i+31:32i] |
| enc_done | output | 1 | Encode results are valid |
| enc_fmt | output | 2 | Chosen format code (0 to 3) |
| enc_payload | output | 256 | Packed payload, unused bits zero |
| enc_bytes | output | 6 | Payload size in bytes |
| dec_valid | input | 1 | Strobe: decode `dec_fmt` and `dec_payload` |
| dec_fmt | input | 2 | Format code of the payload to decode |
| dec_payload | input | 256 | Payload to decode |
| dec_done | output | 1 | `dec_line` is valid |
| dec_line | output | 256 | Rebuilt line |

## Verification
The encoder and the decoder each have a single register stage, so a wrong fit decision, selector bit or packing offset shows up in the cycle right after the strobe. It appears as a wrong format code, a misplaced payload byte or a wrong size. The same fault is confirmed a cycle later, when the payload is decoded and the rebuilt line differs from the original. Boundary offsets sit on both sides of the 8-bit signed range, so an off-by-one fit test changes the format code at once. Lines whose words fit both bases expose a wrong base priority through the selector bits.

// File: rtl/bdi_line_codec.sv
module bdi_line_codec #(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter int DELTA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enc_valid,
  input  logic [WORDS*WORD_W-1:0]   enc_line,
  output logic                      enc_done,
  output logic [1:0]                enc_fmt,
  output logic [WORDS*WORD_W-1:0]   enc_payload,
  output logic [5:0]                enc_bytes,
  input  logic                      dec_valid,
  input  logic [1:0]                dec_fmt,
  input  logic [WORDS*WORD_W-1:0]   dec_payload,
  output logic                      dec_done,
  output logic [WORDS*WORD_W-1:0]   dec_line
);
  localparam int LINE_W = WORDS * WORD_W;
  localparam int MASK_LO = WORD_W;
  localparam int DLT_LO = WORD_W + WORDS;
  localparam int BD_W = WORD_W + WORDS + WORDS * DELTA_W;
  localparam int EXT_W = WORD_W - DELTA_W;
  localparam logic [5:0] SZ_ZERO = 6'd1;
  localparam logic [5:0] SZ_REP = 6'(WORD_W / 8);
  localparam logic [5:0] SZ_BD = 6'(BD_W / 8);
  localparam logic [5:0] SZ_RAW = 6'(LINE_W / 8);

  localparam logic [1:0] F_ZERO = 2'd0;
  localparam logic [1:0] F_REP = 2'd1;
  localparam logic [1:0] F_BD = 2'd2;
  localparam logic [1:0] F_RAW = 2'd3;

  logic [WORD_W-1:0] base;
  logic [WORDS-1:0] is_zero, is_same, fit_z, fit_b;
  logic [WORDS*DELTA_W-1:0] deltas;
  logic [LINE_W-1:0] bd_pl, next_pl;
  logic [1:0] next_fmt;
  logic [5:0] next_bytes;

  assign base = enc_line[WORD_W-1:0];

  for (genvar i = 0; i < WORDS; i++) begin : g_enc
    logic [WORD_W-1:0] w, d;
    assign w = enc_line[i*WORD_W +: WORD_W];
    assign d = w - base;
    assign is_zero[i] = (w == '0);
    assign is_same[i] = (w == base);
    assign fit_z[i] = (w == {{EXT_W{w[DELTA_W-1]}}, w[DELTA_W-1:0]});
    assign fit_b[i] = (d == {{EXT_W{d[DELTA_W-1]}}, d[DELTA_W-1:0]});
    assign deltas[i*DELTA_W +: DELTA_W] = fit_z[i] ? w[DELTA_W-1:0] : d[DELTA_W-1:0];
  end

  assign bd_pl = {{(LINE_W-BD_W){1'b0}}, deltas, fit_z, base};

  always_comb begin
    if (&is_zero) begin
      next_fmt = F_ZERO; next_bytes = SZ_ZERO; next_pl = '0;
    end else if (&is_same) begin
      next_fmt = F_REP; next_bytes = SZ_REP; next_pl = {{(LINE_W-WORD_W){1'b0}}, base};
    end else if (&(fit_z | fit_b)) begin
      next_fmt = F_BD; next_bytes = SZ_BD; next_pl = bd_pl;
    end else begin
      next_fmt = F_RAW; next_bytes = SZ_RAW; next_pl = enc_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_done <= 1'b0;
      enc_fmt <= '0;
      enc_bytes <= '0;
      enc_payload <= '0;
    end else begin
      enc_done <= enc_valid;
      if (enc_valid) begin
        enc_fmt <= next_fmt;
        enc_bytes <= next_bytes;
        enc_payload <= next_pl;
      end
    end
  end

  logic [WORD_W-1:0] d_base;
  logic [LINE_W-1:0] d_bd, d_rep, d_next;
  assign d_base = dec_payload[WORD_W-1:0];

  for (genvar i = 0; i < WORDS; i++) begin : g_dec
    logic [DELTA_W-1:0] dl;
    logic [WORD_W-1:0] sel;
    assign dl = dec_payload[DLT_LO + i*DELTA_W +: DELTA_W];
    assign sel = dec_payload[MASK_LO + i] ? '0 : d_base;
    assign d_bd[i*WORD_W +: WORD_W] = sel + {{EXT_W{dl[DELTA_W-1]}}, dl};
    assign d_rep[i*WORD_W +: WORD_W] = d_base;
  end

  always_comb begin
    case (dec_fmt)
      F_ZERO:  d_next = '0;
      F_REP:   d_next = d_rep;
      F_BD:    d_next = d_bd;
      default: d_next = dec_payload;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_done <= 1'b0;
      dec_line <= '0;
    end else begin
      dec_done <= dec_valid;
      if (dec_valid) dec_line <= d_next;
    end
  end

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> enc_done); // R1
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid |=> !enc_done && $stable(enc_payload) && $stable(enc_fmt)); // R1
  AST_ZERO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && enc_line == '0 |=> enc_fmt == F_ZERO && enc_payload == '0); // R2
  AST_REP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done && enc_fmt == F_REP |-> enc_payload[LINE_W-1:WORD_W] == '0); // R3
  AST_BD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done && enc_fmt == F_BD |-> enc_payload[LINE_W-1:BD_W] == '0); // R4
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && !(&(fit_z | fit_b)) |=> enc_fmt == F_RAW && enc_payload == $past(enc_line)); // R6
  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> dec_done); // R7
  AST_DEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> !dec_done && $stable(dec_line)); // R7
endmodule

// File: tb/sim_bdi_line_codec.sv
module sim_bdi_line_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_valid = 1'b0;
  logic [255:0] enc_line = '0;
  logic enc_done;
  logic [1:0] enc_fmt;
  logic [255:0] enc_payload;
  logic [5:0] enc_bytes;
  logic dec_valid = 1'b0;
  logic [1:0] dec_fmt = '0;
  logic [255:0] dec_payload = '0;
  logic dec_done;
  logic [255:0] dec_line;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bdi_line_codec u0 (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .enc_line(enc_line), .enc_done(enc_done),
    .enc_fmt(enc_fmt), .enc_payload(enc_payload), .enc_bytes(enc_bytes),
    .dec_valid(dec_valid), .dec_fmt(dec_fmt), .dec_payload(dec_payload),
    .dec_done(dec_done), .dec_line(dec_line)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [31:0] w [8]);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = w[i];
    return l;
  endfunction

  task automatic run_enc(input logic [255:0] line);
    @(negedge clk);
    enc_line = line;
    enc_valid = 1'b1;
    @(negedge clk);
    enc_valid = 1'b0;
    chk(enc_done === 1'b1, "R1 done after strobe", {255'd0, enc_done}, 256'd1);
  endtask

  task automatic run_roundtrip(input logic [255:0] line, input string req);
    @(negedge clk);
    dec_fmt = enc_fmt;
    dec_payload = enc_payload;
    dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(dec_done === 1'b1, "R7 decode done", {255'd0, dec_done}, 256'd1);
    chk(dec_line === line, req, dec_line, line);
    @(negedge clk);
    chk(dec_done === 1'b0, "R7 decode done drops", {255'd0, dec_done}, 256'd0);
  endtask

  task automatic t_reset;
    chk(enc_done === 1'b0 && dec_done === 1'b0, "R9 done low", {254'd0, enc_done, dec_done}, 256'd0);
    chk(enc_payload === '0 && enc_fmt === 2'd0 && enc_bytes === 6'd0, "R9 encode outputs zero",
        enc_payload, 256'd0);
    chk(dec_line === '0, "R9 decode line zero", dec_line, 256'd0);
  endtask

  task automatic t_zero;
    run_enc('0);
    chk(enc_fmt === 2'd0 && enc_bytes === 6'd1, "R2 zero format",
        {248'd0, enc_bytes, enc_fmt}, {248'd0, 6'd1, 2'd0});
    chk(enc_payload === '0, "R2 zero payload", enc_payload, 256'd0);
    @(negedge clk);
    chk(enc_done === 1'b0 && enc_fmt === 2'd0, "R1 done one cycle, hold", {255'd0, enc_done}, 256'd0);
    run_roundtrip('0, "R8 zero roundtrip");
  endtask

  task automatic t_repeat;
    logic [31:0] w [8];
    for (int i = 0; i < 8; i++) w[i] = 32'hDEAD_BEEF;
    run_enc(mk(w));
    chk(enc_fmt === 2'd1 && enc_bytes === 6'd4, "R3 repeat format",
        {248'd0, enc_bytes, enc_fmt}, {248'd0, 6'd4, 2'd1});
    chk(enc_payload === {224'd0, 32'hDEAD_BEEF}, "R3 repeat payload", enc_payload, {224'd0, 32'hDEAD_BEEF});
    run_roundtrip(mk(w), "R8 repeat roundtrip");
  endtask

  task automatic t_mixed;
    logic [31:0] w [8];
    logic [255:0] exp;
    w[0] = 32'h8000_1000; w[1] = 32'h0000_0005; w[2] = 32'h8000_1010; w[3] = 32'hFFFF_FFFE;
    w[4] = 32'h8000_0F81; w[5] = 32'h8000_107F; w[6] = 32'h0000_007F; w[7] = 32'h8000_1000;
    exp = '0;
    exp[31:0] = 32'h8000_1000;
    exp[39:32] = 8'b0100_1010;
    exp[40 +: 8] = 8'h00; exp[48 +: 8] = 8'h05; exp[56 +: 8] = 8'h10; exp[64 +: 8] = 8'hFE;
    exp[72 +: 8] = 8'h81; exp[80 +: 8] = 8'h7F; exp[88 +: 8] = 8'h7F; exp[96 +: 8] = 8'h00;
    run_enc(mk(w));
    chk(enc_fmt === 2'd2 && enc_bytes === 6'd13, "R4 base+delta format",
        {248'd0, enc_bytes, enc_fmt}, {248'd0, 6'd13, 2'd2});
    chk(enc_payload === exp, "R4 R10 base+delta payload", enc_payload, exp);
    run_roundtrip(mk(w), "R8 base+delta roundtrip");
  endtask

  task automatic t_both_fit;
    logic [31:0] w [8];
    logic [255:0] exp;
    w[0] = 32'h0000_0003;
    for (int i = 1; i < 8; i++) w[i] = 32'(i);
    exp = '0;
    exp[31:0] = 32'h3;
    exp[39:32] = 8'hFF;
    for (int i = 0; i < 8; i++) exp[40 + i*8 +: 8] = (i == 0) ? 8'h03 : 8'(i);
    run_enc(mk(w));
    chk(enc_fmt === 2'd2, "R5 format", {254'd0, enc_fmt}, 256'd2);
    chk(enc_payload === exp, "R5 zero base preferred", enc_payload, exp);
    run_roundtrip(mk(w), "R8 both-fit roundtrip");
  endtask

  task automatic t_over_plus;
    logic [31:0] w [8];
    for (int i = 0; i < 8; i++) w[i] = 32'h4000_0000;
    w[3] = 32'h4000_0080;
    run_enc(mk(w));
    chk(enc_fmt === 2'd3 && enc_bytes === 6'd32, "R10 R6 +128 not fit",
        {248'd0, enc_bytes, enc_fmt}, {248'd0, 6'd32, 2'd3});
    chk(enc_payload === mk(w), "R6 raw payload", enc_payload, mk(w));
    run_roundtrip(mk(w), "R8 raw roundtrip");
  endtask

  task automatic t_over_minus;
    logic [31:0] w [8];
    for (int i = 0; i < 8; i++) w[i] = 32'h4000_0000;
    w[6] = 32'h3FFF_FF7F;
    run_enc(mk(w));
    chk(enc_fmt === 2'd3, "R10 -129 not fit", {254'd0, enc_fmt}, 256'd3);
    w[6] = 32'h3FFF_FF80;
    run_enc(mk(w));
    chk(enc_fmt === 2'd2 && enc_payload[40 + 6*8 +: 8] === 8'h80 && enc_payload[38] === 1'b0,
        "R10 -128 fits", enc_payload, 256'd0);
    run_roundtrip(mk(w), "R8 -128 roundtrip");
  endtask

  task automatic t_scatter;
    logic [31:0] w [8];
    for (int i = 0; i < 8; i++) w[i] = 32'h1357_9BDF * 32'(i + 1);
    run_enc(mk(w));
    chk(enc_fmt === 2'd3 && enc_payload === mk(w), "R6 scattered words", enc_payload, mk(w));
    run_roundtrip(mk(w), "R8 scattered roundtrip");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zero();
    t_repeat();
    t_mixed();
    t_both_fit();
    t_over_plus();
    t_over_minus();
    t_scatter();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule